// File: doc/BRIEF.md
# Comparison-Driven Binary Search Oscillator Tuner

This controller steers the control code of an on-chip oscillator toward a remote frequency reference. It does not estimate the frequency error directly. For each iteration it asks an external edge accumulator for two counts, one at each edge of the current search window. The count is proportional to the residual error plus a noise bias that both measurements share. The edge that gives the smaller count, together with the current median, forms the next window, so the shared bias cancels in the comparison.

Oscillator frequency is inversely proportional to the code. For that reason the new median is the harmonic mean of the two edge codes and not their average. A multi-cycle restoring divider inside the block computes it. The search runs three times in a fixed order: a coarse stage, then a first fine stage, then a second fine stage. Each stage starts from the result of the one before, uses a narrower initial window and asks for a longer accumulation time. The accumulator learns which stage is active and how long to integrate through dedicated outputs.

Top module: `cbs_freq_search`

## Requirements
- R1: After reset `done` and `meas_req` are 0, `stage` is 0 and `osc_code` is 0.
- R2: A `start` seen while idle or done makes `init_code` the median and selects stage 0. The first request then carries the low-frequency edge code `init_code + (init_code >> SPAN_SHIFT)`, saturated to the all-ones code.
- R3: Each iteration requests the low-frequency edge (the larger code) first and the high-frequency edge (median minus its shift) second. While `meas_req` is high and `meas_ack` is low, `meas_req`, `meas_code`, `meas_len` and `stage` stay unchanged. A one-cycle `meas_ack` delivers `meas_count` and completes the request.
- R4: When the low-edge count is strictly smaller, the next window is {low edge, median}. Otherwise, including the case of equal counts, the next window is {median, high edge}, which keeps the high-frequency half.
- R5: The new median is floor(2·CL·CH/(CL+CH)) for the two edge codes of the new window. At least 2·CW+1 cycles with `meas_req` low separate the high-edge acknowledge from the next request.
- R6: Stages 0, 1 and 2 run in that order, each for ITERS iterations, and `stage` shows the active one. In stage s the edges sit at the median ± (median >> (SPAN_SHIFT + s·ITERS)), and the stage begins from the final median of the stage before it.
- R7: `meas_len` equals ACC_BASE << (s·ITERS) while stage s is active.
- R8: After the last iteration of stage 2, `done` rises and `osc_code` holds the final median. Both stay unchanged and no request is made until a new `start`. A `start` during a search has no effect.
- R9: A `start` while `done` is high begins a fresh search from the new `init_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a three-stage search |
| init_code | input | CW | Free-running code used as the first median |
| meas_req | output | 1 | Measurement request, held until acknowledged |
| meas_code | output | CW | Code to measure at |
| meas_len | output | LW | Accumulation length for the active stage |
| meas_ack | input | 1 | One-cycle acknowledge carrying the count |
| meas_count | input | NW | Accumulated edge count |
| osc_code | output | CW | Current median, final result once done |
| stage | output | 2 | Active tuning stage (0 coarse, 1 fine, 2 finest) |
| done | output | 1 | Search complete, result held |

## Verification
On every cycle the assertions check the request handshake: code, length and stage stay stable while a request waits. They also check that the result and `done` are held with no request once the search is finished, and that the stage index only ever steps forward by one. The window choice, the harmonic-mean arithmetic, the tie rule, saturation at the top code, the divider wait and the stage-dependent spans and lengths are shown only by the bench scenarios. The bench sweeps reference positions around several starting codes and compares every requested code and the final code against an arithmetic model.

// File: rtl/cbs_pkg.sv
// Shared definitions for the comparison-driven binary search tuner.
// Assumes exactly three tuning stages, run in a fixed order.
package cbs_pkg;
    localparam int CBS_NSTAGE = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_MLO,
        S_MHI,
        S_PICK,
        S_DIV,
        S_WAIT,
        S_DONE
    } cbs_state_e;
endpackage

// File: rtl/cbs_edge_gen.sv
// Window edge generator: derives the two edge codes around a median.
// The span shrinks by ITERS bits per stage. The low-frequency edge
// (larger code) saturates at the all-ones code. Purely combinational.
module cbs_edge_gen #(
    parameter int CW         = 16,
    parameter int ITERS      = 4,
    parameter int SPAN_SHIFT = 5
) (
    input  logic [CW-1:0] med,
    input  logic [1:0]    stage,
    output logic [CW-1:0] lo_code,
    output logic [CW-1:0] hi_code
);
    import cbs_pkg::*;

    logic [CW-1:0] delta_tab [CBS_NSTAGE];
    logic [CW-1:0] delta;
    logic [CW:0]   sum;

    // one span per stage, each narrower by ITERS binary steps
    for (genvar s = 0; s < CBS_NSTAGE; s++) begin : g_span
        assign delta_tab[s] = med >> (SPAN_SHIFT + s * ITERS);
    end

    // select the span of the active stage
    always_comb begin
        delta = delta_tab[0];
        for (int s = 1; s < CBS_NSTAGE; s++) begin
            if (int'(stage) == s) delta = delta_tab[s];
        end
    end

    // form the edges, saturating the upper one
    always_comb begin
        sum     = {1'b0, med} + {1'b0, delta};
        lo_code = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
        hi_code = med - delta;
    end
endmodule

// File: rtl/cbs_hm_div.sv
// Harmonic-mean unit: on go it captures a and b, then computes
// floor(2ab/(a+b)) by restoring division, one quotient bit per
// cycle over 2*CW+1 cycles. fin pulses for one cycle when q is
// valid. Assumes a+b is nonzero.
module cbs_hm_div #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [CW-1:0] a,
    input  logic [CW-1:0] b,
    output logic          fin,
    output logic [CW-1:0] q
);
    localparam int QW = 2 * CW + 1;
    localparam int DW = CW + 1;
    localparam int KW = $clog2(QW + 1);

    logic [QW-1:0]   quo;
    logic [DW-1:0]   rem;
    logic [DW-1:0]   den;
    logic [KW-1:0]   cnt;
    logic            run;
    logic [2*CW-1:0] prod;
    logic [DW:0]     rem_sh;
    logic            ge;
    logic [DW-1:0]   rem_nx;

    // operand product for the numerator
    always_comb prod = {{CW{1'b0}}, a} * {{CW{1'b0}}, b};

    // one restoring step
    always_comb begin
        rem_sh = {rem, quo[QW-1]};
        ge     = rem_sh >= {1'b0, den};
        rem_nx = ge ? DW'(rem_sh - {1'b0, den}) : rem_sh[DW-1:0];
    end

    // iteration control and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo <= '0;
            rem <= '0;
            den <= '0;
            cnt <= '0;
            run <= 1'b0;
            fin <= 1'b0;
        end else if (go) begin
            quo <= {prod, 1'b0};
            rem <= '0;
            den <= {1'b0, a} + {1'b0, b};
            cnt <= KW'(QW);
            run <= 1'b1;
            fin <= 1'b0;
        end else if (run) begin
            quo <= {quo[QW-2:0], ge};
            rem <= rem_nx;
            cnt <= cnt - 1'b1;
            if (cnt == KW'(1)) begin
                run <= 1'b0;
                fin <= 1'b1;
            end
        end else begin
            fin <= 1'b0;
        end
    end

    assign q = quo[CW-1:0];
endmodule

// File: rtl/cbs_window.sv
// Search window registers: the low-frequency edge code, the
// high-frequency edge code and the median. The edges are loaded
// at stage entry. A pick replaces one edge with the median, and
// the median is written separately.
module cbs_window #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] lo_in,
    input  logic [CW-1:0] hi_in,
    input  logic          pick,
    input  logic          keep_low,
    input  logic          med_wr,
    input  logic [CW-1:0] med_in,
    output logic [CW-1:0] cl,
    output logic [CW-1:0] ch,
    output logic [CW-1:0] cm
);
    // edge registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cl <= '0;
            ch <= '0;
        end else if (load) begin
            cl <= lo_in;
            ch <= hi_in;
        end else if (pick) begin
            if (keep_low) ch <= cm;
            else          cl <= cm;
        end
    end

    // median register
    always_ff @(posedge clk) begin
        if (!rst_n)      cm <= '0;
        else if (med_wr) cm <= med_in;
    end
endmodule

// File: rtl/cbs_freq_search.sv
// Comparison-driven binary search tuner (top). Each iteration
// measures both window edges through a req/ack handshake. It keeps
// the half on the side of the smaller count (ties keep the
// high-frequency half) and sets the new median to the harmonic mean
// of the remaining edges. Three stages run in order, with ITERS
// iterations each. Assumes meas_ack pulses only while meas_req is high.
module cbs_freq_search #(
    parameter int CW         = 16,
    parameter int LW         = 24,
    parameter int NW         = 20,
    parameter int ITERS      = 4,
    parameter int SPAN_SHIFT = 5,
    parameter int ACC_BASE   = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] init_code,
    output logic          meas_req,
    output logic [CW-1:0] meas_code,
    output logic [LW-1:0] meas_len,
    input  logic          meas_ack,
    input  logic [NW-1:0] meas_count,
    output logic [CW-1:0] osc_code,
    output logic [1:0]    stage,
    output logic          done
);
    import cbs_pkg::*;

    localparam int IW = $clog2(ITERS + 1);

    cbs_state_e    st;
    logic [IW-1:0] iter;
    logic [NW-1:0] n_lo;
    logic [NW-1:0] n_hi;
    logic [CW-1:0] cl, ch, cm;
    logic [CW-1:0] lo_edge, hi_edge;
    logic [CW-1:0] div_q;
    logic          div_fin;
    logic          idle_like;
    logic          med_wr;
    logic [CW-1:0] med_in;
    logic [LW-1:0] len_tab [CBS_NSTAGE];

    assign idle_like = (st == S_IDLE) || (st == S_DONE);

    cbs_edge_gen #(.CW(CW), .ITERS(ITERS), .SPAN_SHIFT(SPAN_SHIFT)) u_edge (
        .med     (cm),
        .stage   (stage),
        .lo_code (lo_edge),
        .hi_code (hi_edge)
    );

    cbs_window #(.CW(CW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (st == S_LOAD),
        .lo_in    (lo_edge),
        .hi_in    (hi_edge),
        .pick     (st == S_PICK),
        .keep_low (n_lo < n_hi),
        .med_wr   (med_wr),
        .med_in   (med_in),
        .cl       (cl),
        .ch       (ch),
        .cm       (cm)
    );

    cbs_hm_div #(.CW(CW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (st == S_DIV),
        .a     (cl),
        .b     (ch),
        .fin   (div_fin),
        .q     (div_q)
    );

    // accumulation length per stage, longer for finer resolution
    for (genvar s = 0; s < CBS_NSTAGE; s++) begin : g_len
        assign len_tab[s] = LW'(ACC_BASE) << (s * ITERS);
    end

    // median write source: start code or divider result
    always_comb begin
        med_wr = (idle_like && start) || (st == S_WAIT && div_fin);
        med_in = (st == S_WAIT) ? div_q : init_code;
    end

    // sequencing of stages, iterations and measurements
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= S_IDLE;
            stage <= 2'd0;
            iter  <= '0;
            n_lo  <= '0;
            n_hi  <= '0;
        end else begin
            unique case (st)
                S_IDLE, S_DONE: begin
                    if (start) begin
                        stage <= 2'd0;
                        iter  <= '0;
                        st    <= S_LOAD;
                    end
                end
                S_LOAD: st <= S_MLO;
                S_MLO: begin
                    if (meas_ack) begin
                        n_lo <= meas_count;
                        st   <= S_MHI;
                    end
                end
                S_MHI: begin
                    if (meas_ack) begin
                        n_hi <= meas_count;
                        st   <= S_PICK;
                    end
                end
                S_PICK: st <= S_DIV;
                S_DIV:  st <= S_WAIT;
                S_WAIT: begin
                    if (div_fin) begin
                        if (iter == IW'(ITERS - 1)) begin
                            iter <= '0;
                            if (int'(stage) == CBS_NSTAGE - 1) begin
                                st <= S_DONE;
                            end else begin
                                stage <= stage + 2'd1;
                                st    <= S_LOAD;
                            end
                        end else begin
                            iter <= iter + 1'b1;
                            st   <= S_MLO;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // handshake and result outputs
    always_comb begin
        meas_req  = (st == S_MLO) || (st == S_MHI);
        meas_code = (st == S_MHI) ? ch : cl;
        meas_len  = len_tab[0];
        for (int s = 1; s < CBS_NSTAGE; s++) begin
            if (int'(stage) == s) meas_len = len_tab[s];
        end
        osc_code = cm;
        done     = (st == S_DONE);
    end
endmodule

// File: rtl/cbs_freq_search_chk.sv
// Property checker for cbs_freq_search, bound to every instance.
// It watches the handshake, the result hold and the stage order.
module cbs_freq_search_chk #(
    parameter int CW = 16,
    parameter int LW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          meas_req,
    input logic          meas_ack,
    input logic [CW-1:0] meas_code,
    input logic [LW-1:0] meas_len,
    input logic [CW-1:0] osc_code,
    input logic [1:0]    stage,
    input logic          done
);
    logic past_ok;

    // marks that one clean cycle has passed since reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_req && !meas_ack |=> meas_req && $stable(meas_code)
                                  && $stable(meas_len) && $stable(stage));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(osc_code));

    // R8
    no_req_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !meas_req);

    // R6
    stage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && (stage != $past(stage))
        |-> (stage == $past(stage) + 2'd1) || (stage == 2'd0));
endmodule

bind cbs_freq_search cbs_freq_search_chk #(.CW(CW), .LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .meas_req  (meas_req),
    .meas_ack  (meas_ack),
    .meas_code (meas_code),
    .meas_len  (meas_len),
    .osc_code  (osc_code),
    .stage     (stage),
    .done      (done)
);

// File: tb/tb_cbs_freq_search.sv
// Bench for cbs_freq_search: sweeps reference positions around
// several start codes and checks each request and the final code
// against an arithmetic model of the search.
module tb_cbs_freq_search;
    localparam int CW = 12, LW = 16, NW = 16, ITERS = 3, SPAN = 5, ACCB = 16;
    localparam int QW = 2 * CW + 1;
    localparam int NREQ = 3 * 2 * ITERS;
    localparam int MAXC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] init_code = '0;
    logic          meas_req;
    logic [CW-1:0] meas_code;
    logic [LW-1:0] meas_len;
    logic          meas_ack = 1'b0;
    logic [NW-1:0] meas_count = '0;
    logic [CW-1:0] osc_code;
    logic [1:0]    stage;
    logic          done;

    int checks = 0, failures = 0;
    int tgt = 0, tie_mode = 0, idx = 0, gap = 0, exp_final = 0;
    int exp_code [NREQ];
    int exp_stage [NREQ];

    always #2 clk = ~clk;

    cbs_freq_search #(.CW(CW), .LW(LW), .NW(NW), .ITERS(ITERS),
                      .SPAN_SHIFT(SPAN), .ACC_BASE(ACCB)) dut (.*);

    function automatic int cnt_of(int code);
        if (tie_mode != 0) return 9;
        return ((code > tgt) ? code - tgt : tgt - code) + 3;
    endfunction

    // reference model of the search (R2..R6)
    task automatic build_model(int init);
        int cm, cl, ch, d, k;
        cm = init; k = 0;
        for (int s = 0; s < 3; s++) begin
            d  = cm >> (SPAN + s * ITERS);
            cl = cm + d;
            if (cl > MAXC) cl = MAXC;
            ch = cm - d;
            for (int i = 0; i < ITERS; i++) begin
                exp_code[k] = cl; exp_stage[k] = s; k++;
                exp_code[k] = ch; exp_stage[k] = s; k++;
                if (cnt_of(cl) < cnt_of(ch)) ch = cm;
                else                         cl = cm;
                cm = (2 * cl * ch) / (cl + ch);
            end
        end
        exp_final = cm;
    endtask

    // accumulator model: answers requests, checks code/stage/len/gap
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && meas_req) begin
                checks++;
                if (idx >= NREQ) begin
                    failures++;
                    $display("FAIL R8 extra request idx=%0d got code %0d expected none", idx, meas_code);
                end else if (int'(meas_code) != exp_code[idx] || int'(stage) != exp_stage[idx]
                             || int'(meas_len) != (ACCB << (exp_stage[idx] * ITERS))) begin
                    failures++;
                    $display("FAIL R3/R4/R6/R7 req %0d got code=%0d stage=%0d len=%0d expected code=%0d stage=%0d len=%0d",
                             idx, meas_code, stage, meas_len, exp_code[idx], exp_stage[idx],
                             ACCB << (exp_stage[idx] * ITERS));
                end
                if (idx > 0 && idx % 2 == 0) begin
                    checks++;
                    if (gap < QW) begin
                        failures++;
                        $display("FAIL R5 divider gap got %0d expected >= %0d", gap, QW);
                    end
                end
                repeat (idx % 4) @(negedge clk);
                meas_ack   = 1'b1;
                meas_count = NW'(cnt_of(int'(meas_code)));
                idx++;
                @(negedge clk);
                meas_ack = 1'b0;
                gap = 0;
            end else begin
                gap++;
            end
        end
    end

    task automatic check(bit ok, string req, int got, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic run(int init, int t, int tie, bit poke);
        bit fin_seen;
        tgt = t; tie_mode = tie;
        build_model(init);
        idx = 0;
        @(negedge clk);
        init_code = CW'(init);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            init_code = CW'(100);
            start = 1'b1;                 // R8: ignored mid-search
            @(negedge clk);
            start = 1'b0;
        end
        fin_seen = 1'b0;
        for (int c = 0; c < 4000 && !fin_seen; c++) begin
            @(negedge clk);
            fin_seen = done;
        end
        check(fin_seen, "R8 done reached", int'(done), 1);
        check(int'(osc_code) == exp_final, "R5/R6 final code", int'(osc_code), exp_final);
        check(idx == NREQ, "R6 request count", idx, NREQ);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(done == 1'b0 && meas_req == 1'b0, "R1 done/req at reset", {done, meas_req}, 0);
        check(stage == 2'd0 && osc_code == '0, "R1 stage/code at reset", int'(osc_code) + int'(stage), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(meas_req == 1'b0, "R1 idle without start", int'(meas_req), 0);

        // R2 R4 R9 sweep of reference positions; starts after the first come from done
        foreach (exp_code[i]) exp_code[i] = 0;
        for (int b = 0; b < 2; b++) begin
            int base;
            base = (b == 0) ? 1200 : 2600;
            for (int t = base - base * 4 / 100; t <= base + base * 4 / 100; t += base / 100)
                run(base, t, 0, 1'b0);
        end
        // R2 saturation of the low-frequency edge
        run(4000, 3950, 0, 1'b0);
        run(4000, 4090, 0, 1'b0);
        // R4 equal counts keep the high-frequency half
        run(1800, 0, 1, 1'b0);
        // R8 start during a search is ignored
        run(2000, 2031, 0, 1'b1);

        // R8 result held after completion
        repeat (15) @(negedge clk);
        check(done == 1'b1, "R8 done held", int'(done), 1);
        check(int'(osc_code) == exp_final, "R8 code held", int'(osc_code), exp_final);
        check(meas_req == 1'b0 && idx == NREQ, "R8 no request while done", idx, NREQ);

        // R9 fresh start from done with a new code
        run(1500, 1480, 0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule